// File: doc/BRIEF.md
# Serial Command Word Receiver with Chainable Data Output

This block is the digital front end of a serially programmed converter. It runs entirely on a fast system clock and treats the external serial clock, the active-low chip select and the serial data line as plain asynchronous inputs. Each input passes through a two-flop synchronizer. Edges are then found on the synchronized copies. A 16-bit word is collected most significant bit first. When chip select returns high, the collected word goes to a downstream command decoder together with a one-cycle valid strobe.

The last stage of the shift register also drives a serial data output. Several devices can therefore be chained, or a host can read back what it sent. A mode input selects which serial clock edge updates that output, which moves the input-to-output lag by half a serial clock. A hold input from the power-management logic freezes the output level while the downstream device is shut down. The system clock must run at least four times faster than the serial clock, and each serial clock phase must last at least two system clocks.

Top module: `ser_word_shifter`

## Requirements
- R1: On each synchronized rising edge of the serial clock while chip select is low, the data bit is shifted into bit 0 of the 16-bit register and the older bits move one place toward bit 15. The first bit sent therefore ends up as the most significant bit, and a frame longer than 16 bits keeps only its last 16 bits.
- R2: While chip select is high, serial clock edges and data changes do not move the shift register. The serial output shows the same bits afterwards that it would have shown without that activity.
- R3: A word sent as two 8-bit bursts, with the serial clock idle between them while chip select stays low, is received the same as one 16-bit burst.
- R4: On a synchronized rising edge of chip select, after at least 16 bits, the word output takes the register contents and the valid strobe is high for exactly one system clock. The word output changes at no other time.
- R5: A frame with fewer than 16 serial clock rising edges between the falling and rising edges of chip select raises no strobe and leaves the word output unchanged.
- R6: With mode input 0 (the default), the serial output takes the value of register bit 15 on each serial clock falling edge. A bit shifted in at rising edge k therefore appears after falling edge k+15.
- R7: With mode input 1, the serial output takes the value that register bit 15 held before the shift, on each serial clock rising edge. A bit shifted in at rising edge k therefore appears after rising edge k+16, half a serial clock later than in mode 0.
- R8: While the hold input is high, the serial output keeps its level. Shifting and word capture continue as normal.
- R9: A synchronous reset clears the shift register, the word output, the strobe and the serial output, and selects mode 0 until the mode input is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial clock |
| csn_in | input | 1 | Asynchronous chip select, active low |
| sdi_in | input | 1 | Asynchronous serial data in |
| edge_mode_in | input | 1 | 0: output updates on serial clock fall; 1: on rise |
| hold_in | input | 1 | Freeze the serial output level |
| word_o | output | 16 | Last complete received word |
| word_vld_o | output | 1 | One-cycle strobe when a word is handed over |
| sdo_o | output | 1 | Serial data out (register last stage) |

## Verification
A table of words is sent in both output-edge modes: all-ones, all-zeros-but-one at each end, and alternating patterns. The single-bit words show that the bit order and the end bits of the register are correct. The alternating words show whether the serial output is sampled on the right edge. At every serial clock half-period the serial output is compared with a reference shift register kept in the bench, so a half-clock error in the lag is caught. Directed frames cover a short frame, an over-long frame, a split frame with an idle gap, serial activity with chip select high, and a hold period. These separate a lost-word fault, a wrong-window fault, a gating fault and a freeze fault.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } dout_edge_e;

  localparam int unsigned IDX_SCK = 0;
  localparam int unsigned IDX_CSN = 1;
  localparam int unsigned IDX_SDI = 2;
  localparam int unsigned N_SER   = 3;
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sws_edge.sv
module sws_edge #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
    assign fall_o[i] = ~lvl_i[i] & prev_q[i];
  end
endmodule

// File: rtl/sws_shift.sv
module sws_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise_i,
  input  logic              cs_low_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] shreg_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (cs_fall_i) begin
        cnt_q <= '0;
      end else if (sck_rise_i && cs_low_i) begin
        sr_q <= {sr_q[WORD_W-2:0], sdi_i};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_rise_i && cnt_q == FULL) begin
        word_o     <= sr_q;
        word_vld_o <= 1'b1;
      end
    end
  end

  assign shreg_o = sr_q;
endmodule

// File: rtl/sws_dout.sv
module sws_dout
  import sws_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic hold_i,
  input  logic sck_rise_i,
  input  logic sck_fall_i,
  input  logic last_i,
  output logic sdo_o
);
  dout_edge_e mode_q;
  logic       upd;

  assign upd = !hold_i &&
               ((mode_q == EDGE_RISE && sck_rise_i) ||
                (mode_q == EDGE_FALL && sck_fall_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= EDGE_FALL;
      sdo_o  <= 1'b0;
    end else begin
      mode_q <= dout_edge_e'(mode_i);
      if (upd) sdo_o <= last_i;
    end
  end
endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
  import sws_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              csn_in,
  input  logic              sdi_in,
  input  logic              edge_mode_in,
  input  logic              hold_in,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              sdo_o
);
  localparam logic [N_SER-1:0] IDLE = N_SER'(1) << IDX_CSN;

  logic [N_SER-1:0]  raw, lvl, rise, fall;
  logic [WORD_W-1:0] shreg_q;
  logic              cs_s;

  assign raw[IDX_SCK] = sclk_in;
  assign raw[IDX_CSN] = csn_in;
  assign raw[IDX_SDI] = sdi_in;
  assign cs_s         = lvl[IDX_CSN];

  sws_sync #(.W(N_SER), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(lvl)
  );

  sws_edge #(.W(N_SER), .RST_VAL(IDLE)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  sws_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .sck_rise_i(rise[IDX_SCK]),
    .cs_low_i(!cs_s),
    .cs_fall_i(fall[IDX_CSN]),
    .cs_rise_i(rise[IDX_CSN]),
    .sdi_i(lvl[IDX_SDI]),
    .shreg_o(shreg_q),
    .word_o(word_o),
    .word_vld_o(word_vld_o)
  );

  sws_dout u_dout (
    .clk(clk), .rst(rst),
    .mode_i(edge_mode_in),
    .hold_i(hold_in),
    .sck_rise_i(rise[IDX_SCK]),
    .sck_fall_i(fall[IDX_SCK]),
    .last_i(shreg_q[WORD_W-1]),
    .sdo_o(sdo_o)
  );
endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_in,
  input logic              cs_s,
  input logic [WORD_W-1:0] shreg_q,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              sdo_o
);
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  a_r4_word_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (word_o != $past(word_o)) |-> word_vld_o);

  a_r2_frozen_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> $stable(shreg_q));

  a_r8_hold_keeps_output: assert property (@(posedge clk) disable iff (rst)
    hold_in |=> $stable(sdo_o));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (sdo_o == 1'b0 && !word_vld_o && word_o == '0));
endmodule

bind ser_word_shifter sws_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .hold_in(hold_in), .cs_s(cs_s),
  .shreg_q(shreg_q), .word_o(word_o), .word_vld_o(word_vld_o), .sdo_o(sdo_o)
);

// File: tb/tb_ser_word_shifter.sv
module tb_ser_word_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_in = 1'b0, csn_in = 1'b1, sdi_in = 1'b0;
  logic        edge_mode_in = 1'b0, hold_in = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o, sdo_o;

  int n_chk = 0, n_bad = 0, vld_cnt = 0;
  bit done = 0;
  logic [15:0] ref_sr = '0;
  logic        exp_sdo = 1'b0;
  string       tag = "R9";

  // bit 16 = output-edge mode, bits 15:0 = word
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'hA5C3}, {1'b1, 16'h0001}, {1'b0, 16'h8000},
    {1'b1, 16'hFFFF}, {1'b0, 16'h1234}, {1'b1, 16'h0F0F}
  };

  always #2 clk = ~clk;

  ser_word_shifter dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .csn_in(csn_in), .sdi_in(sdi_in),
    .edge_mode_in(edge_mode_in), .hold_in(hold_in),
    .word_o(word_o), .word_vld_o(word_vld_o), .sdo_o(sdo_o)
  );

  always @(posedge clk) if (word_vld_o) vld_cnt++;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock period; sclk is low on entry and on exit
  task automatic sbit(input logic b);
    sdi_in = b;
    wait_n(6);
    sclk_in = 1'b1;
    if (edge_mode_in && !hold_in) exp_sdo = ref_sr[15];
    if (!csn_in) ref_sr = {ref_sr[14:0], b};
    wait_n(5);
    chk({tag, " sdo after rise"}, {31'b0, sdo_o}, {31'b0, exp_sdo});
    wait_n(1);
    sclk_in = 1'b0;
    if (!edge_mode_in && !hold_in) exp_sdo = ref_sr[15];
    wait_n(5);
    chk({tag, " sdo after fall"}, {31'b0, sdo_o}, {31'b0, exp_sdo});
    wait_n(1);
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic cs_low();
    csn_in = 1'b0;
    wait_n(6);
  endtask

  task automatic cs_high();
    wait_n(6);
    csn_in = 1'b1;
    wait_n(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v0;
    logic [15:0] prev_word;
    wait_n(4);
    rst = 1'b0;
    wait_n(4);
    // R9: reset state
    chk("R9 word after reset", {16'b0, word_o}, 32'h0);
    chk("R9 strobe after reset", {31'b0, word_vld_o}, 32'h0);
    chk("R9 sdo after reset", {31'b0, sdo_o}, 32'h0);

    // table of words in both output-edge modes (R1, R4, R6, R7)
    for (int i = 0; i < 6; i++) begin
      edge_mode_in = VEC[i][16];
      tag = VEC[i][16] ? "R7" : "R6";
      wait_n(4);
      v0 = vld_cnt;
      cs_low();
      send({16'b0, VEC[i][15:0]}, 16);
      cs_high();
      chk("R1 word received", {16'b0, word_o}, {16'b0, VEC[i][15:0]});
      chk("R4 one strobe per word", vld_cnt - v0, 1);
    end

    // R5: short frame discarded
    edge_mode_in = 1'b0;
    tag = "R5";
    wait_n(4);
    prev_word = word_o;
    v0 = vld_cnt;
    cs_low();
    send(32'h2AB, 10);
    cs_high();
    chk("R5 no strobe on short frame", vld_cnt - v0, 0);
    chk("R5 word kept", {16'b0, word_o}, {16'b0, prev_word});

    // R1: over-long frame keeps last 16 bits
    tag = "R1";
    v0 = vld_cnt;
    cs_low();
    send(32'h000F_BEEF, 20);
    cs_high();
    chk("R1 long frame keeps last 16", {16'b0, word_o}, 32'h0000_BEEF);
    chk("R1 long frame strobe", vld_cnt - v0, 1);

    // R3: two 8-bit bursts with idle gap
    tag = "R3";
    v0 = vld_cnt;
    cs_low();
    send(32'hC6, 8);
    wait_n(40);
    send(32'h39, 8);
    cs_high();
    chk("R3 split word", {16'b0, word_o}, 32'h0000_C639);
    chk("R3 split strobe", vld_cnt - v0, 1);

    // R2: activity with chip select high
    tag = "R2";
    prev_word = word_o;
    v0 = vld_cnt;
    send(32'h5A, 8);
    chk("R2 no strobe while deselected", vld_cnt - v0, 0);
    chk("R2 word kept while deselected", {16'b0, word_o}, {16'b0, prev_word});
    cs_low();
    send(32'h7E81, 16);  // sdo checks expose the preserved register contents
    cs_high();
    chk("R2 word after deselected activity", {16'b0, word_o}, 32'h7E81);

    // R8: hold freezes the serial output, capture continues
    tag = "R8";
    hold_in = 1'b1;
    cs_low();
    send(32'hA55A, 16);
    cs_high();
    chk("R8 word captured under hold", {16'b0, word_o}, 32'hA55A);
    hold_in = 1'b0;
    edge_mode_in = 1'b1;
    tag = "R7";
    wait_n(4);
    cs_low();
    send(32'h0FF0, 16);
    cs_high();
    chk("R7 word after hold", {16'b0, word_o}, 32'h0FF0);

    // R9: reset mid-run restores default mode and clears the register
    rst = 1'b1;
    edge_mode_in = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(4);
    ref_sr = '0;
    exp_sdo = 1'b0;
    tag = "R9";
    chk("R9 word after second reset", {16'b0, word_o}, 32'h0);
    chk("R9 sdo after second reset", {31'b0, sdo_o}, 32'h0);
    cs_low();
    send(32'hFFFF, 16);
    cs_high();
    chk("R9 word after second reset frame", {16'b0, word_o}, 32'hFFFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule